// File: doc/BRIEF.md
# Exclusive Transfer Rule Checker

A passive monitor that sits beside a pipelined system bus and looks at every transfer the bus accepts. When a master marks a new transfer as exclusive, the monitor checks the properties that an exclusive access must have. It must be a single beat. Its burst encoding must allow a single-beat access. It must not be interrupted by a BUSY cycle. Its address must be naturally aligned to its size. Finally, the same master must not start another exclusive access while its previous one is still in its data phase. The monitor never drives the bus.

Each broken rule sets its own sticky flag, which stays set until software or a test harness pulses the synchronous clear. On every clock edge where a violation is detected, the monitor also raises a one-cycle pulse together with the ID of the master that caused it. This makes it suitable both as a silicon debug aid and as a protocol sentinel in system simulation. Pending data phases are tracked per master ID, so exclusives from different masters may overlap freely.

Top module: `excl_rule_checker`

## Requirements
- R1: A transfer is an exclusive start only when, at a rising edge with `hready_i` high, `hexcl_i` is 1 and `htrans_i` is NONSEQ (2'b10). The other transfer codes are IDLE=2'b00, BUSY=2'b01 and SEQ=2'b11. `hexcl_i` together with IDLE, or with a non-exclusive NONSEQ, never raises any flag or pulse.
- R2: For an exclusive start, `hburst_i` of 3'b000 (single) or 3'b001 (undefined-length incrementing) is legal. Any other code sets flag bit 0.
- R3: After an exclusive start, an accepted SEQ transfer sets flag bit 1. The burst stays open through accepted SEQ and BUSY cycles and closes on an accepted IDLE or NONSEQ.
- R4: An accepted BUSY transfer while an exclusive burst is open sets flag bit 2.
- R5: For an exclusive start, any set bit of `haddr_i` below bit position `hsize_i` sets flag bit 3. For example, size 2 with address 0x2 is a violation, and size 1 with address 0x2 is legal.
- R6: The data phase of an exclusive start from master m is pending from its accepting edge until the next edge with `hready_i` high. A new exclusive start from the same master at that next edge sets flag bit 4, whatever wait states lie in between.
- R7: An exclusive start from one master while a different master's exclusive data phase is pending raises no flag. Once a pending phase has completed, that master may start a new exclusive without a flag.
- R8: Flags are sticky and are cleared only by `clr_i` high at a rising edge. A violation detected at the same edge as a clear still sets its own flag.
- R9: `viol_pulse_o` is high for exactly the one cycle after each edge that detects a violation. `viol_master_o` then holds the offending master's ID. For R3 and R4 this is the master that made the exclusive start.
- R10: After reset all outputs are zero. Flags and the pulse update at the same rising edge where the offending transfer is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the sticky flags |
| htrans_i | input | 2 | Transfer type |
| hburst_i | input | 3 | Burst encoding |
| hsize_i | input | 3 | Transfer size, log2 bytes |
| haddr_i | input | ADDR_W | Transfer address |
| hexcl_i | input | 1 | Exclusive marker |
| hmaster_i | input | MASTER_W | Master ID of the current address phase |
| hready_i | input | 1 | Transfer accepted / previous data phase done |
| viol_o | output | 5 | Sticky flags: 0 burst, 1 multi-beat, 2 busy, 3 alignment, 4 overlap |
| viol_pulse_o | output | 1 | One-cycle violation strobe |
| viol_master_o | output | MASTER_W | Master ID tied to the strobe |

## Verification
Every result is registered exactly once. The flags, the strobe and the master ID for a transfer are all due at the rising edge that accepts that transfer, with no added latency. The one exception is a multi-beat or BUSY violation: it belongs to the beat that follows the exclusive start, so it is due at the edge that accepts that beat. The bench changes inputs on the falling edge and reads outputs on the next falling edge. Each read therefore shows the result of exactly the one edge in between. The one-cycle nature of the strobe is checked by the sample taken after the following clean cycle.

// File: rtl/excl_chk_pkg.sv
package excl_chk_pkg;
  localparam int NUM_RULES = 5;

  localparam int RULE_BURST   = 0;
  localparam int RULE_BEATS   = 1;
  localparam int RULE_BUSY    = 2;
  localparam int RULE_ALIGN   = 3;
  localparam int RULE_OVERLAP = 4;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;

  typedef logic [NUM_RULES-1:0] rule_vec_t;
endpackage

// File: rtl/excl_rule_decode.sv
module excl_rule_decode
  import excl_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        htrans_i,
  input  logic [2:0]        hburst_i,
  input  logic [2:0]        hsize_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic              hexcl_i,
  input  logic              hready_i,
  input  logic              burst_open_i,
  output logic              excl_start_o,
  output logic              burst_bad_o,
  output logic              align_bad_o,
  output logic              beats_bad_o,
  output logic              busy_bad_o
);
  logic misalign;

  always_comb begin
    misalign = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < int'(hsize_i) && haddr_i[i]) misalign = 1'b1;
    end
  end

  assign excl_start_o = hready_i && hexcl_i && (htrans_i == TR_NONSEQ);
  assign burst_bad_o  = excl_start_o && !(hburst_i == BU_SINGLE || hburst_i == BU_INCR);
  assign align_bad_o  = excl_start_o && misalign;
  // continuation beats of an open exclusive burst
  assign beats_bad_o  = hready_i && burst_open_i && (htrans_i == TR_SEQ);
  assign busy_bad_o   = hready_i && burst_open_i && (htrans_i == TR_BUSY);
endmodule

// File: rtl/excl_pending_track.sv
module excl_pending_track
  import excl_chk_pkg::*;
#(
  parameter int MASTER_W    = 4,
  parameter int NUM_MASTERS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hready_i,
  input  logic [1:0]          htrans_i,
  input  logic                excl_start_i,
  input  logic [MASTER_W-1:0] hmaster_i,
  output logic                own_pending_o,
  output logic                burst_open_o,
  output logic [MASTER_W-1:0] burst_master_o
);
  logic [NUM_MASTERS-1:0] pend_q;
  logic [NUM_MASTERS-1:0] hit;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    logic sel;
    assign sel    = (int'(hmaster_i) == m);
    assign hit[m] = pend_q[m] && sel;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[m] <= 1'b0;
      else if (hready_i) pend_q[m] <= excl_start_i && sel;
    end
  end

  assign own_pending_o = |hit;

  logic                burst_q;
  logic [MASTER_W-1:0] bmst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      bmst_q  <= '0;
    end else if (hready_i) begin
      if (excl_start_i) begin
        burst_q <= 1'b1;
        bmst_q  <= hmaster_i;
      end else if (htrans_i == TR_IDLE || htrans_i == TR_NONSEQ) begin
        burst_q <= 1'b0;
      end
    end
  end

  assign burst_open_o   = burst_q;
  assign burst_master_o = bmst_q;
endmodule

// File: rtl/excl_viol_log.sv
module excl_viol_log
  import excl_chk_pkg::*;
#(
  parameter int MASTER_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  rule_vec_t           hit_i,
  input  logic [MASTER_W-1:0] src_master_i,
  output rule_vec_t           viol_o,
  output logic                viol_pulse_o,
  output logic [MASTER_W-1:0] viol_master_o
);
  rule_vec_t           flags_q;
  logic                pulse_q;
  logic [MASTER_W-1:0] mst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pulse_q <= 1'b0;
      mst_q   <= '0;
    end else begin
      flags_q <= (clr_i ? '0 : flags_q) | hit_i;
      pulse_q <= |hit_i;
      if (|hit_i) mst_q <= src_master_i;
    end
  end

  assign viol_o        = flags_q;
  assign viol_pulse_o  = pulse_q;
  assign viol_master_o = mst_q;
endmodule

// File: rtl/excl_rule_checker.sv
module excl_rule_checker
  import excl_chk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MASTER_W    = 4,
  parameter int NUM_MASTERS = 1 << MASTER_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [1:0]           htrans_i,
  input  logic [2:0]           hburst_i,
  input  logic [2:0]           hsize_i,
  input  logic [ADDR_W-1:0]    haddr_i,
  input  logic                 hexcl_i,
  input  logic [MASTER_W-1:0]  hmaster_i,
  input  logic                 hready_i,
  output logic [NUM_RULES-1:0] viol_o,
  output logic                 viol_pulse_o,
  output logic [MASTER_W-1:0]  viol_master_o
);
  logic excl_start, burst_bad, align_bad, beats_bad, busy_bad;
  logic own_pending, burst_open;
  logic [MASTER_W-1:0] burst_master;
  rule_vec_t hits;
  logic [MASTER_W-1:0] src_master;

  excl_rule_decode #(.ADDR_W(ADDR_W)) u_decode (
    .htrans_i     (htrans_i),
    .hburst_i     (hburst_i),
    .hsize_i      (hsize_i),
    .haddr_i      (haddr_i),
    .hexcl_i      (hexcl_i),
    .hready_i     (hready_i),
    .burst_open_i (burst_open),
    .excl_start_o (excl_start),
    .burst_bad_o  (burst_bad),
    .align_bad_o  (align_bad),
    .beats_bad_o  (beats_bad),
    .busy_bad_o   (busy_bad)
  );

  excl_pending_track #(.MASTER_W(MASTER_W), .NUM_MASTERS(NUM_MASTERS)) u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hready_i       (hready_i),
    .htrans_i       (htrans_i),
    .excl_start_i   (excl_start),
    .hmaster_i      (hmaster_i),
    .own_pending_o  (own_pending),
    .burst_open_o   (burst_open),
    .burst_master_o (burst_master)
  );

  always_comb begin
    hits               = '0;
    hits[RULE_BURST]   = burst_bad;
    hits[RULE_BEATS]   = beats_bad;
    hits[RULE_BUSY]    = busy_bad;
    hits[RULE_ALIGN]   = align_bad;
    hits[RULE_OVERLAP] = excl_start && own_pending;
  end

  // SEQ/BUSY and NONSEQ hits never coincide, so the source is unambiguous
  assign src_master = (beats_bad || busy_bad) ? burst_master : hmaster_i;

  excl_viol_log #(.MASTER_W(MASTER_W)) u_log (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr_i),
    .hit_i         (hits),
    .src_master_i  (src_master),
    .viol_o        (viol_o),
    .viol_pulse_o  (viol_pulse_o),
    .viol_master_o (viol_master_o)
  );
endmodule

// File: rtl/excl_rule_checker_sva.sv
module excl_rule_checker_sva
  import excl_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clr_i,
  input logic [1:0]           htrans_i,
  input logic [2:0]           hburst_i,
  input logic [2:0]           hsize_i,
  input logic [ADDR_W-1:0]    haddr_i,
  input logic                 hexcl_i,
  input logic                 hready_i,
  input logic [NUM_RULES-1:0] viol_o,
  input logic                 viol_pulse_o
);
  p_idle_no_viol_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && htrans_i == TR_IDLE) |=> !viol_pulse_o);

  p_plain_nonseq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && !hexcl_i && htrans_i == TR_NONSEQ) |=> !viol_pulse_o);

  p_burst_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hexcl_i && htrans_i == TR_NONSEQ && hburst_i > 3'd1)
      |=> (viol_o[RULE_BURST] && viol_pulse_o));

  p_align_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hexcl_i && htrans_i == TR_NONSEQ && hsize_i == 3'd1 && haddr_i[0])
      |=> viol_o[RULE_ALIGN]);

  p_flags_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  p_pulse_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_pulse_o |-> (viol_o != '0));
endmodule

bind excl_rule_checker excl_rule_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .htrans_i     (htrans_i),
  .hburst_i     (hburst_i),
  .hsize_i      (hsize_i),
  .haddr_i      (haddr_i),
  .hexcl_i      (hexcl_i),
  .hready_i     (hready_i),
  .viol_o       (viol_o),
  .viol_pulse_o (viol_pulse_o)
);

// File: tb/tb_excl_rule_checker.sv
`timescale 1ns/1ps
module tb_excl_rule_checker;
  localparam int AW = 32;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic [1:0]    htrans = 2'b00;
  logic [2:0]    hburst = 3'b000;
  logic [2:0]    hsize = 3'b010;
  logic [AW-1:0] haddr = '0;
  logic          hexcl = 1'b0;
  logic [MW-1:0] hmaster = '0;
  logic          hready = 1'b1;
  logic [4:0]    viol;
  logic          vpulse;
  logic [MW-1:0] vmaster;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  excl_rule_checker #(.ADDR_W(AW), .MASTER_W(MW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .htrans_i(htrans), .hburst_i(hburst), .hsize_i(hsize), .haddr_i(haddr),
    .hexcl_i(hexcl), .hmaster_i(hmaster), .hready_i(hready),
    .viol_o(viol), .viol_pulse_o(vpulse), .viol_master_o(vmaster)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply one transfer, let one rising edge pass, return at the falling edge
  task automatic cyc(logic [1:0] tr, logic [2:0] bu, logic [2:0] sz,
                     logic [AW-1:0] ad, logic ex, logic [MW-1:0] ms,
                     logic rdy, logic cl);
    htrans = tr; hburst = bu; hsize = sz; haddr = ad;
    hexcl = ex; hmaster = ms; hready = rdy; clr = cl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(2'b00, 3'b000, 3'b010, '0, 1'b0, '0, 1'b1, 1'b0);
  endtask

  task automatic clear();
    cyc(2'b00, 3'b000, 3'b010, '0, 1'b0, '0, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    chk("R10 flags", int'(viol), 0);
    chk("R10 pulse", int'(vpulse), 0);
    chk("R10 master", int'(vmaster), 0);
  endtask

  task automatic t_idle_excl();
    clear();
    cyc(2'b00, 3'b011, 3'b010, 32'h3, 1'b1, 4'd7, 1'b1, 1'b0);
    chk("R1 idle excl pulse", int'(vpulse), 0);
    chk("R1 idle excl flags", int'(viol), 0);
    cyc(2'b10, 3'b011, 3'b010, 32'h3, 1'b0, 4'd7, 1'b1, 1'b0);
    chk("R1 plain nonseq flags", int'(viol), 0);
    idle();
  endtask

  task automatic t_burst();
    clear();
    cyc(2'b10, 3'b000, 3'b010, 32'h100, 1'b1, 4'd1, 1'b1, 1'b0);
    idle();
    cyc(2'b10, 3'b001, 3'b010, 32'h104, 1'b1, 4'd1, 1'b1, 1'b0);
    chk("R2 single/incr legal", int'(viol), 0);
    idle();
    cyc(2'b10, 3'b011, 3'b010, 32'h108, 1'b1, 4'd9, 1'b1, 1'b0);
    chk("R2 incr4 flag", int'(viol), 5'b00001);
    chk("R9 burst pulse", int'(vpulse), 1);
    chk("R9 burst master", int'(vmaster), 9);
    idle();
    chk("R9 pulse one cycle", int'(vpulse), 0);
    chk("R8 sticky", int'(viol), 5'b00001);
    clear();
    chk("R8 cleared", int'(viol), 0);
  endtask

  task automatic t_seq();
    clear();
    cyc(2'b10, 3'b001, 3'b010, 32'h200, 1'b1, 4'd3, 1'b1, 1'b0);
    chk("R3 start clean", int'(vpulse), 0);
    cyc(2'b11, 3'b001, 3'b010, 32'h204, 1'b0, 4'd3, 1'b1, 1'b0);
    chk("R3 seq flag", int'(viol), 5'b00010);
    chk("R9 seq master", int'(vmaster), 3);
    idle();
  endtask

  task automatic t_busy();
    clear();
    cyc(2'b10, 3'b001, 3'b010, 32'h300, 1'b1, 4'd12, 1'b1, 1'b0);
    cyc(2'b01, 3'b001, 3'b010, 32'h304, 1'b0, 4'd0, 1'b1, 1'b0);
    chk("R4 busy flag", int'(viol), 5'b00100);
    chk("R4 busy master", int'(vmaster), 12);
    idle();
  endtask

  task automatic t_align();
    clear();
    cyc(2'b10, 3'b000, 3'b001, 32'h2, 1'b1, 4'd4, 1'b1, 1'b0);
    chk("R5 half at 0x2 legal", int'(viol), 0);
    idle();
    cyc(2'b10, 3'b000, 3'b010, 32'h2, 1'b1, 4'd4, 1'b1, 1'b0);
    chk("R5 word at 0x2 flag", int'(viol), 5'b01000);
    idle();
  endtask

  task automatic t_overlap();
    clear();
    cyc(2'b10, 3'b000, 3'b010, 32'h400, 1'b1, 4'd5, 1'b1, 1'b0);
    cyc(2'b10, 3'b000, 3'b010, 32'h400, 1'b1, 4'd5, 1'b1, 1'b0);
    chk("R6 back-to-back flag", int'(viol), 5'b10000);
    chk("R6 master", int'(vmaster), 5);
    idle();
    clear();
    cyc(2'b10, 3'b000, 3'b010, 32'h400, 1'b1, 4'd5, 1'b1, 1'b0);
    cyc(2'b10, 3'b000, 3'b010, 32'h400, 1'b1, 4'd5, 1'b0, 1'b0);
    chk("R6 wait state no early flag", int'(vpulse), 0);
    cyc(2'b10, 3'b000, 3'b010, 32'h400, 1'b1, 4'd5, 1'b1, 1'b0);
    chk("R6 flag after wait", int'(viol), 5'b10000);
    idle();
  endtask

  task automatic t_other_master();
    clear();
    cyc(2'b10, 3'b000, 3'b010, 32'h500, 1'b1, 4'd2, 1'b1, 1'b0);
    cyc(2'b10, 3'b000, 3'b010, 32'h600, 1'b1, 4'd6, 1'b1, 1'b0);
    chk("R7 other master", int'(viol), 0);
    idle();
    cyc(2'b10, 3'b000, 3'b010, 32'h500, 1'b1, 4'd2, 1'b1, 1'b0);
    chk("R7 after completion", int'(viol), 0);
    idle();
  endtask

  task automatic t_clear_race();
    cyc(2'b10, 3'b000, 3'b010, 32'h1, 1'b1, 4'd8, 1'b1, 1'b0);
    chk("R8 preset align", int'(viol), 5'b01000);
    idle();
    cyc(2'b10, 3'b010, 3'b000, 32'h0, 1'b1, 4'd8, 1'b1, 1'b1);
    chk("R8 clear with new hit", int'(viol), 5'b00001);
    idle();
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_excl();
    t_burst();
    t_seq();
    t_busy();
    t_align();
    t_overlap();
    t_other_master();
    t_clear_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule